// File: doc/BRIEF.md
# Alert class escalation timer

This block sequences the escalation response of a single alert class. It waits in an idle state until the class is triggered. A trigger is either a direct escalation request from the accumulation logic or an interrupt that software leaves unserviced for too long. The block then steps through four timed escalation phases and parks in a terminal state.

In every phase the block raises one of its escalation request outputs. A programmable per-phase field selects which output, and a per-output enable can mask it. A running cycle counter and a state code are exported so that surrounding logic can observe the block's progress.

The class takes part only while its master enable is set and at least one per-output enable is also set. Clearing every per-output enable therefore silences the whole class.

Top module: `class_esc_timer`

## Requirements
- R1: While reset is asserted and right after it, `state_o` is 0 (idle), `cnt_o` is 0 and `esc_o` is all zero.
- R2: State codes are idle=0, timeout wait=1, phase 0..3 = 2..5, terminal=6. In idle with the class effectively enabled, `trig_i` high at a clock edge moves the block to phase 0 (code 2) with `cnt_o`=1 at that edge.
- R3: In phase p the counter runs 1,2,..,D, where D is the duration field `phase_cyc_i[p*CNT_W +: CNT_W]` and a value of 0 counts as 1. On the edge after the counter equals D, the block enters phase p+1 with `cnt_o`=1. After phase 3 it enters terminal with `cnt_o`=0.
- R4: In idle with the class effectively enabled, `irq_i` high and `tmo_cyc_i` nonzero, the block enters the timeout wait with `cnt_o`=1. The counter then rises by one per cycle while `irq_i` stays high. On the edge after `cnt_o` equals `tmo_cyc_i`, the block enters phase 0 with `cnt_o`=1. A `tmo_cyc_i` of 0 never enters the wait.
- R5: In the timeout wait, without a trigger, a low `irq_i` or a high `clr_i` returns the block to idle with `cnt_o`=0 on the next edge.
- R6: In the timeout wait, `trig_i` with the class effectively enabled moves the block to phase 0, and this takes priority over a simultaneous `clr_i`.
- R7: The class is effectively enabled only when `class_en_i` is 1 and `sig_en_i` is nonzero. Otherwise idle ignores both `trig_i` and `irq_i`.
- R8: In phase p, output j of `esc_o` is high exactly when the 2-bit map field `map_i[2p+1:2p]` equals j and `sig_en_i[j]` is 1. At most one output is high, and all outputs are low outside the four phases.
- R9: `clr_i` has no effect in phases 0 to 3.
- R10: Terminal is held with `cnt_o`=0 until `clr_i`, which returns the block to idle with `cnt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Direct escalation trigger from class accumulation |
| irq_i | input | 1 | Class interrupt pending |
| clr_i | input | 1 | Clear request |
| class_en_i | input | 1 | Class master enable |
| sig_en_i | input | N_SIG | Per-output escalation enables |
| tmo_cyc_i | input | CNT_W | Interrupt timeout in cycles, 0 disables the timeout |
| phase_cyc_i | input | 4*CNT_W | Phase durations, phase p at bits p*CNT_W upward |
| map_i | input | 4*MAP_W | Phase-to-output map, phase p at bits p*MAP_W upward |
| esc_o | output | N_SIG | Escalation requests |
| state_o | output | 3 | State code |
| cnt_o | output | CNT_W | Running cycle counter |

## Verification
The clear request and the direct trigger can arrive in the same cycle while the block waits on an unhandled interrupt. The bench drives both high on one edge during the timeout wait and expects phase 0 with a count of 1, not idle. A clear is also pulsed inside a running phase, where the bench expects the phase and its count to continue unchanged. Throughout the run, a behavioural reference model sets the expected state, count and outputs, and the bench compares them with the design every cycle.

// File: rtl/esc_timer_pkg.sv
`timescale 1ns/1ps
package esc_timer_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WAIT = 3'd1,
      ST_PH0  = 3'd2,
      ST_PH1  = 3'd3,
      ST_PH2  = 3'd4,
      ST_PH3  = 3'd5,
      ST_TERM = 3'd6
   } esc_state_e;

   localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/esc_class_gate.sv
`timescale 1ns/1ps
// Effective class enable: master bit and at least one output enable.
module esc_class_gate #(
   parameter int unsigned N_SIG = 4
) (
   input  logic             master_i,
   input  logic [N_SIG-1:0] sig_en_i,
   output logic             class_on_o
);
   if (N_SIG < 1) begin : g_bad_nsig
      $error("esc_class_gate: N_SIG must be at least 1");
   end

   logic any_sig;
   always_comb begin
      any_sig = 1'b0;
      for (int j = 0; j < N_SIG; j++) any_sig = any_sig | sig_en_i[j];
   end

   assign class_on_o = master_i & any_sig;
endmodule

// File: rtl/esc_phase_fsm.sv
`timescale 1ns/1ps
// Sequencer: idle, interrupt timeout wait, four phases, terminal.
module esc_phase_fsm
   import esc_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        class_on_i,
   input  logic                        trig_i,
   input  logic                        irq_i,
   input  logic                        clr_i,
   input  logic [CNT_W-1:0]            tmo_i,
   input  logic [NUM_PHASES*CNT_W-1:0] dur_i,
   output esc_state_e                  state_o,
   output logic [CNT_W-1:0]            cnt_o,
   output logic                        phase_act_o,
   output logic [1:0]                  phase_idx_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cntw
      $error("esc_phase_fsm: CNT_W must lie in 2..64");
   end

   esc_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] dur_arr [NUM_PHASES];
   logic [CNT_W-1:0] dur_eff;
   logic             phase_act;
   logic [1:0]       phase_idx;

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_dur
      assign dur_arr[p] = dur_i[p*CNT_W +: CNT_W];
   end

   always_comb begin
      phase_act = 1'b1;
      phase_idx = 2'd0;
      case (state_q)
         ST_PH0:  phase_idx = 2'd0;
         ST_PH1:  phase_idx = 2'd1;
         ST_PH2:  phase_idx = 2'd2;
         ST_PH3:  phase_idx = 2'd3;
         default: phase_act = 1'b0;
      endcase
   end

   assign dur_eff = (dur_arr[phase_idx] == '0) ? ONE : dur_arr[phase_idx];

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      case (state_q)
         ST_IDLE: begin
            if (class_on_i && trig_i) begin
               state_d = ST_PH0;
               cnt_d   = ONE;
            end else if (class_on_i && irq_i && (tmo_i != '0)) begin
               state_d = ST_WAIT;
               cnt_d   = ONE;
            end
         end
         ST_WAIT: begin
            if (class_on_i && trig_i) begin
               state_d = ST_PH0;
               cnt_d   = ONE;
            end else if (!class_on_i || clr_i || !irq_i) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end else if (cnt_q >= tmo_i) begin
               state_d = ST_PH0;
               cnt_d   = ONE;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
         ST_PH0, ST_PH1, ST_PH2, ST_PH3: begin
            if (cnt_q >= dur_eff) begin
               if (state_q == ST_PH3) begin
                  state_d = ST_TERM;
                  cnt_d   = '0;
               end else begin
                  state_d = esc_state_e'(state_q + 3'd1);
                  cnt_d   = ONE;
               end
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
         ST_TERM: begin
            if (clr_i) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o     = state_q;
   assign cnt_o       = cnt_q;
   assign phase_act_o = phase_act;
   assign phase_idx_o = phase_idx;

   assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && class_on_i && trig_i) |=> (state_q == ST_PH0 && cnt_q == ONE));

   assert_wait_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT && class_on_i && !trig_i && !clr_i && irq_i && cnt_q < tmo_i)
      |=> (state_q == ST_WAIT && cnt_q == $past(cnt_q) + ONE));

   assert_wait_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT && !trig_i && (clr_i || !irq_i)) |=> (state_q == ST_IDLE && cnt_q == '0));

   assert_trig_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT && class_on_i && trig_i) |=> (state_q == ST_PH0));

   assert_idle_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && !class_on_i) |=> (state_q == ST_IDLE));

   assert_phase_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_act |=> (state_q == $past(state_q) || {1'b0, state_q} == {1'b0, $past(state_q)} + 4'd1));

   assert_term_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_TERM && !clr_i) |=> (state_q == ST_TERM && cnt_q == '0));

   assert_term_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_TERM && clr_i) |=> (state_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/esc_sig_map.sv
`timescale 1ns/1ps
// Routes the active phase to one escalation output through the map.
module esc_sig_map #(
   parameter int unsigned N_SIG  = 4,
   parameter int unsigned MAP_W  = 2,
   parameter int unsigned N_PH   = 4
) (
   input  logic                  phase_act_i,
   input  logic [1:0]            phase_idx_i,
   input  logic [N_PH*MAP_W-1:0] map_i,
   input  logic [N_SIG-1:0]      sig_en_i,
   output logic [N_SIG-1:0]      esc_o
);
   if (MAP_W < 1 || (1 << MAP_W) < N_SIG) begin : g_bad_mapw
      $error("esc_sig_map: MAP_W too narrow for N_SIG");
   end

   logic [MAP_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int p = 0; p < N_PH; p++) begin
         if (phase_idx_i == 2'(p)) sel = map_i[p*MAP_W +: MAP_W];
      end
   end

   for (genvar j = 0; j < N_SIG; j++) begin : g_out
      assign esc_o[j] = phase_act_i & sig_en_i[j] & (sel == MAP_W'(j));
   end
endmodule

// File: rtl/class_esc_timer.sv
`timescale 1ns/1ps
module class_esc_timer
   import esc_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned N_SIG = 4,
   localparam int unsigned MAP_W = (N_SIG > 1) ? $clog2(N_SIG) : 1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        trig_i,
   input  logic                        irq_i,
   input  logic                        clr_i,
   input  logic                        class_en_i,
   input  logic [N_SIG-1:0]            sig_en_i,
   input  logic [CNT_W-1:0]            tmo_cyc_i,
   input  logic [NUM_PHASES*CNT_W-1:0] phase_cyc_i,
   input  logic [NUM_PHASES*MAP_W-1:0] map_i,
   output logic [N_SIG-1:0]            esc_o,
   output logic [2:0]                  state_o,
   output logic [CNT_W-1:0]            cnt_o
);
   if (N_SIG < 2 || N_SIG > 16) begin : g_bad_nsig
      $error("class_esc_timer: N_SIG must lie in 2..16");
   end

   logic       class_on;
   esc_state_e state;
   logic       phase_act;
   logic [1:0] phase_idx;

   esc_class_gate #(.N_SIG(N_SIG)) u_gate (
      .master_i   (class_en_i),
      .sig_en_i   (sig_en_i),
      .class_on_o (class_on)
   );

   esc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .class_on_i  (class_on),
      .trig_i      (trig_i),
      .irq_i       (irq_i),
      .clr_i       (clr_i),
      .tmo_i       (tmo_cyc_i),
      .dur_i       (phase_cyc_i),
      .state_o     (state),
      .cnt_o       (cnt_o),
      .phase_act_o (phase_act),
      .phase_idx_o (phase_idx)
   );

   esc_sig_map #(.N_SIG(N_SIG), .MAP_W(MAP_W), .N_PH(NUM_PHASES)) u_map (
      .phase_act_i (phase_act),
      .phase_idx_i (phase_idx),
      .map_i       (map_i),
      .sig_en_i    (sig_en_i),
      .esc_o       (esc_o)
   );

   assign state_o = state;

   assert_single_esc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(esc_o));

   assert_quiet_outside_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o < 3'd2 || state_o > 3'd5) |-> (esc_o == '0));

   assert_reset_state_R1: assert property (@(posedge clk_i)
      !rst_ni |-> (state_o == 3'd0 && cnt_o == '0 && esc_o == '0));
endmodule

// File: tb/class_esc_timer_test.sv
`timescale 1ns/1ps
module class_esc_timer_test;
   localparam int CW = 16;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0, irq = 1'b0, clr = 1'b0, cen = 1'b1;
   logic [NS-1:0] sen = 4'hF;
   logic [CW-1:0] tmo = 16'd5;
   logic [4*CW-1:0] dur;
   logic [7:0]    map = 8'hE4;
   logic [NS-1:0] esc;
   logic [2:0]    st;
   logic [CW-1:0] cnt;

   int pass_n = 0, fail_n = 0;
   int m_st = 0, m_cnt = 0;

   always #2 clk = ~clk;

   class_esc_timer #(.CNT_W(CW), .N_SIG(NS)) uut (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .irq_i(irq), .clr_i(clr),
      .class_en_i(cen), .sig_en_i(sen), .tmo_cyc_i(tmo), .phase_cyc_i(dur),
      .map_i(map), .esc_o(esc), .state_o(st), .cnt_o(cnt)
   );

   task automatic chk(string tag, int act, int exp);
      if (act == exp) pass_n++;
      else begin
         fail_n++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int dur_of(int p);
      int d = int'(dur[p*CW +: CW]);
      return (d == 0) ? 1 : d;
   endfunction

   function automatic int model_esc();
      int sel;
      if (m_st < 2 || m_st > 5) return 0;
      sel = (int'(map) >> (2 * (m_st - 2))) & 3;
      return sen[sel] ? (1 << sel) : 0;
   endfunction

   // Behavioural reference model (R2..R7, R9, R10)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0;
      end else begin
         automatic bit en = cen && (sen != 0);
         case (m_st)
            0: if (en && trig) begin m_st = 2; m_cnt = 1; end
               else if (en && irq && tmo != 0) begin m_st = 1; m_cnt = 1; end
            1: if (en && trig) begin m_st = 2; m_cnt = 1; end
               else if (!en || clr || !irq) begin m_st = 0; m_cnt = 0; end
               else if (m_cnt >= int'(tmo)) begin m_st = 2; m_cnt = 1; end
               else m_cnt++;
            2, 3, 4, 5:
               if (m_cnt >= dur_of(m_st - 2)) begin
                  if (m_st == 5) begin m_st = 6; m_cnt = 0; end
                  else begin m_st++; m_cnt = 1; end
               end else m_cnt++;
            6: if (clr) begin m_st = 0; m_cnt = 0; end
            default: begin m_st = 0; m_cnt = 0; end
         endcase
      end
   end

   // Per-cycle comparison against the model, 1 ns after each falling edge
   always begin
      @(negedge clk);
      #1;
      chk("R3 model state", int'(st), m_st);
      chk("R3 model count", int'(cnt), m_cnt);
      chk("R8 model esc", int'(esc), model_esc());
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clear();
      clr = 1'b1; cyc(1); clr = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      fail_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end

   initial begin
      dur = {16'd4, 16'd0, 16'd2, 16'd3};
      cyc(1);
      #1;
      chk("R1 reset state", int'(st), 0);
      chk("R1 reset count", int'(cnt), 0);
      chk("R1 reset esc", int'(esc), 0);
      cyc(2);
      rst_n = 1'b1;
      cyc(2);

      // Direct trigger and full phase walk, default map
      trig = 1'b1; cyc(1); trig = 1'b0;
      #1; chk("R2 phase0 entry", int'(st), 2); chk("R2 count 1", int'(cnt), 1);
      chk("R8 default map phase0", int'(esc), 1);
      cyc(3); #1; chk("R3 phase1 entry", int'(st), 3); chk("R8 phase1 esc", int'(esc), 2);
      clr = 1'b1; cyc(1); clr = 1'b0;
      #1; chk("R9 clear ignored state", int'(st), 3); chk("R9 clear ignored count", int'(cnt), 2);
      cyc(1); #1; chk("R3 zero duration phase2", int'(st), 4);
      cyc(1); #1; chk("R3 phase3 after one cycle", int'(st), 5); chk("R8 phase3 esc", int'(esc), 8);
      cyc(4); #1; chk("R3 terminal", int'(st), 6); chk("R3 terminal count", int'(cnt), 0);
      cyc(5); #1; chk("R10 terminal held", int'(st), 6); chk("R10 terminal esc low", int'(esc), 0);
      pulse_clear(); #1; chk("R10 clear to idle", int'(st), 0); chk("R10 count zero", int'(cnt), 0);

      // Interrupt timeout path
      irq = 1'b1; cyc(1);
      #1; chk("R4 wait entry", int'(st), 1); chk("R4 wait count", int'(cnt), 1);
      cyc(4); #1; chk("R4 count at limit", int'(cnt), 5);
      cyc(1); #1; chk("R4 timeout to phase0", int'(st), 2); chk("R4 phase0 count", int'(cnt), 1);
      cyc(10); #1; chk("R4 reached terminal", int'(st), 6);
      irq = 1'b0; pulse_clear(); #1; chk("R10 clear after timeout run", int'(st), 0);

      // Leaving the wait
      irq = 1'b1; cyc(2); #1; chk("R4 wait count two", int'(cnt), 2);
      irq = 1'b0; cyc(1); #1; chk("R5 irq drop to idle", int'(st), 0); chk("R5 count zero", int'(cnt), 0);
      irq = 1'b1; cyc(2);
      clr = 1'b1; cyc(1); clr = 1'b0; irq = 1'b0;
      #1; chk("R5 clear to idle", int'(st), 0);
      cyc(1);

      // Trigger and clear in the same cycle during the wait
      irq = 1'b1; cyc(2);
      trig = 1'b1; clr = 1'b1; cyc(1); trig = 1'b0; clr = 1'b0; irq = 1'b0;
      #1; chk("R6 trigger beats clear", int'(st), 2); chk("R6 count 1", int'(cnt), 1);
      cyc(10); #1; chk("R6 run to terminal", int'(st), 6);
      pulse_clear();

      // Enable gating
      sen = 4'h0; trig = 1'b1; irq = 1'b1; cyc(3); trig = 1'b0; irq = 1'b0;
      #1; chk("R7 no output enables", int'(st), 0);
      sen = 4'hF; cen = 1'b0; trig = 1'b1; irq = 1'b1; cyc(2); trig = 1'b0; irq = 1'b0;
      #1; chk("R7 master off", int'(st), 0);
      cen = 1'b1; tmo = 16'd0; irq = 1'b1; cyc(3); irq = 1'b0;
      #1; chk("R4 zero timeout stays idle", int'(st), 0);
      tmo = 16'd5;

      // Remapped phases with one output suppressed
      map = 8'h4F; sen = 4'b1101;
      trig = 1'b1; cyc(1); trig = 1'b0;
      #1; chk("R8 remap phase0 to out3", int'(esc), 8);
      cyc(3); #1; chk("R8 remap phase1 to out3", int'(esc), 8);
      cyc(2); #1; chk("R8 remap phase2 to out0", int'(esc), 1);
      cyc(1); #1; chk("R8 phase3 suppressed", int'(esc), 0); chk("R8 still phase3", int'(st), 5);
      cyc(4); #1; chk("R10 terminal after remap", int'(st), 6);
      pulse_clear(); cyc(2);

      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end
endmodule